// File: doc/BRIEF.md
# Serial Flash Block-Erase Responder

This block is an SPI target that behaves like the erase side of a serial flash device, with a small on-chip byte array behind it. A host arms the device with a write-enable command. It then sends a one-byte erase opcode and a 24-bit address. When chip-select is released after a well-formed frame, the block fills the addressed block with 0xFF. The fill runs over a fixed, self-timed number of system clocks, and a busy flag covers that interval. The host can poll the flag, together with the write-enable latch, through a status-read command.

There are two erase sizes. The small block holds 2^BLK_AW bytes and the large block holds twice that, so the scale of the array follows the parameters. An address range input marks bytes as protected. An erase whose block touches that range is dropped without effect. A direct inspection port lets a test environment preload the array and read it back.

The SPI pins are oversampled in the system clock domain: two synchronising flops, then edge detection. SCK must therefore stay well below the system clock; three system clocks per SCK phase is the minimum. MEM_AW must be at least 8 and at least BLK_AW+1. ERASE_CYCLES must be at least 2^(BLK_AW+1).

Top module: `spi_erase_resp`

## Requirements
- R1: Opcode 0x52 sets every byte of one small block (2^BLK_AW bytes) to 0xFF. Opcode 0xD8 does the same for one large block (2^(BLK_AW+1) bytes). Bytes outside the block keep their values. Any other opcode sent in a 32-bit frame changes no byte.
- R2: The block is picked from the low MEM_AW bits of the 24-bit address, with the bits below the block size cleared. Address bits at or above MEM_AW have no effect.
- R3: When prot_en is 1 and the chosen block shares at least one byte with the inclusive range prot_lo..prot_hi, the erase is dropped and the array is unchanged. A block that ends just below prot_lo is erased.
- R4: An erase is carried out only when the write-enable latch is set. The latch is set by opcode 0x06 in a frame of exactly 8 bits. A 0x06 frame of any other length leaves the latch as it was.
- R5: Commands are acted on only at the rising edge of cs_n. An erase frame of any length other than exactly 32 bits (8 opcode bits, then 24 address bits, MSB first) is discarded. It leaves both the array and the latch unchanged.
- R6: From the cycle after an erase is accepted, the busy flag is 1 for exactly ERASE_CYCLES system clocks, then returns to 0.
- R7: Every complete 32-bit erase frame received while not busy clears the write-enable latch, whether or not the erase is carried out.
- R8: While busy is 1, write-enable and erase frames are ignored. Status reads still answer.
- R9: Opcode 0x05 returns the status byte {6'b0, latch, busy}, with busy in bit 0 and the latch in bit 1. Bits go out MSB first and change after SCK falling edges, so the host samples on rising edges in SPI mode 0 or mode 3. miso_oe is 1 only during the data phase of a status read while cs_n is low; the pad is undriven otherwise.
- R10: insp_rdata shows the array byte at insp_addr, with no clock delay. insp_we writes insp_wdata there while not busy, and is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso_d | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the miso pad |
| prot_en | input | 1 | Enables the protected range |
| prot_lo | input | MEM_AW | First protected byte address |
| prot_hi | input | MEM_AW | Last protected byte address |
| insp_addr | input | MEM_AW | Inspection port byte address |
| insp_we | input | 1 | Inspection port write strobe |
| insp_wdata | input | 8 | Inspection port write data |
| insp_rdata | output | 8 | Inspection port read data |

## Verification
The bench builds the block with MEM_AW=9, BLK_AW=6 and ERASE_CYCLES=500. This gives a 512-byte array of eight small or four large blocks, so the whole array can be compared after every erase. The protected window can be placed to overlap a block by one byte or to sit one byte past it. The 500-cycle busy window is long enough for a full status read, a write-enable frame and an inspection write all to land inside it. It is also short enough to wait out between vectors. Address values with non-zero bits above bit 8 show that the high bits fold away.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

  localparam logic [7:0] OPC_WEN   = 8'h06;
  localparam logic [7:0] OPC_STAT  = 8'h05;
  localparam logic [7:0] OPC_ERS_S = 8'h52;
  localparam logic [7:0] OPC_ERS_L = 8'hD8;

  localparam int CMD_BITS   = 8;
  localparam int ERASE_BITS = 32;

  // first byte of the block containing a
  function automatic logic [23:0] blk_floor(input logic [23:0] a, input int unsigned sh);
    return (a >> sh) << sh;
  endfunction

  // last byte of the block starting at base
  function automatic logic [23:0] blk_top(input logic [23:0] base, input int unsigned sh);
    return base + ((24'd1 << sh) - 24'd1);
  endfunction

  // inclusive spans [a0,a1] and [b0,b1] share a byte
  function automatic logic spans_meet(input logic [23:0] a0, input logic [23:0] a1,
                                      input logic [23:0] b0, input logic [23:0] b1);
    return (a0 <= b1) && (b0 <= a1);
  endfunction

  function automatic logic [7:0] stat_byte(input logic busy, input logic wel);
    return {6'b0, wel, busy};
  endfunction

endpackage

// File: rtl/spi_erase_link.sv
module spi_erase_link
  import spi_erase_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LOC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic [7:0]       stat_in,
  output logic             frame_active,
  output logic             frame_end,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [7:0]       opcode,
  output logic [LOC_W-1:0] addr_lo,
  output logic             miso_d,
  output logic             miso_oe
);

  logic [2:0]       sck_s;
  logic [1:0]       cs_s;
  logic             cs_d;
  logic [1:0]       mosi_s;
  logic [LOC_W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       opc;
  logic [7:0]       sr;
  logic             miso_q;

  logic cs_lo, sck_rise, sck_fall, frame_begin, mosi_b, rd_phase;
  logic [7:0] first_byte;

  assign cs_lo       = ~cs_s[1];
  assign sck_rise    = cs_lo & sck_s[1] & ~sck_s[2];
  assign sck_fall    = cs_lo & ~sck_s[1] & sck_s[2];
  assign frame_begin = cs_d & ~cs_s[1];
  assign frame_end   = ~cs_d & cs_s[1];
  assign mosi_b      = mosi_s[1];
  assign first_byte  = {sh[6:0], mosi_b};
  assign rd_phase    = cs_lo && (opc == OPC_STAT) && (cnt >= CNT_W'(CMD_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      cs_s   <= 2'b11;
      cs_d   <= 1'b1;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      cs_s   <= {cs_s[0], cs_n};
      cs_d   <= cs_s[1];
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      opc    <= '0;
      sr     <= '0;
      miso_q <= 1'b0;
    end else if (frame_begin) begin
      cnt    <= '0;
      opc    <= '0;
      miso_q <= 1'b0;
    end else if (sck_rise) begin
      sh <= {sh[LOC_W-2:0], mosi_b};
      if (cnt != '1) cnt <= cnt + CNT_W'(1);
      if (cnt == CNT_W'(7)) opc <= first_byte;
      if (cnt[2:0] == 3'd7 &&
          ((cnt == CNT_W'(7)) ? (first_byte == OPC_STAT) : (opc == OPC_STAT)))
        sr <= stat_in;
    end else if (sck_fall && rd_phase) begin
      miso_q <= sr[7];
      sr     <= {sr[6:0], 1'b0};
    end
  end

  assign frame_active = cs_lo;
  assign bit_cnt      = cnt;
  assign opcode       = opc;
  assign addr_lo      = sh;
  assign miso_d       = miso_q;
  assign miso_oe      = rd_phase;

endmodule

// File: rtl/spi_erase_cmd.sv
module spi_erase_cmd
  import spi_erase_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int BLK_AW = 6,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [7:0]        opcode,
  input  logic [MEM_AW-1:0] addr_lo,
  input  logic              busy,
  input  logic              prot_en,
  input  logic [MEM_AW-1:0] prot_lo,
  input  logic [MEM_AW-1:0] prot_hi,
  output logic              wel,
  output logic              erase_start,
  output logic [MEM_AW-1:0] erase_base,
  output logic              erase_big,
  output logic              prot_hit
);

  localparam int BIG_AW = BLK_AW + 1;

  logic        is_big, is_ers, len_cmd, len_ers;
  int unsigned blk_sh;
  logic [23:0] b0, b1;

  assign is_big  = (opcode == OPC_ERS_L);
  assign is_ers  = is_big || (opcode == OPC_ERS_S);
  assign len_cmd = (bit_cnt == CNT_W'(CMD_BITS));
  assign len_ers = (bit_cnt == CNT_W'(ERASE_BITS));

  always_comb begin
    blk_sh   = is_big ? BIG_AW : BLK_AW;
    b0       = blk_floor(24'(addr_lo), blk_sh);
    b1       = blk_top(b0, blk_sh);
    prot_hit = prot_en && spans_meet(b0, b1, 24'(prot_lo), 24'(prot_hi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel         <= 1'b0;
      erase_start <= 1'b0;
      erase_base  <= '0;
      erase_big   <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      if (frame_end && !busy) begin
        if (opcode == OPC_WEN && len_cmd) wel <= 1'b1;
        if (is_ers && len_ers) begin
          wel <= 1'b0;
          if (wel && !prot_hit) begin
            erase_start <= 1'b1;
            erase_base  <= b0[MEM_AW-1:0];
            erase_big   <= is_big;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_erase_engine.sv
module spi_erase_engine #(
  parameter int MEM_AW       = 10,
  parameter int BLK_AW       = 6,
  parameter int ERASE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEM_AW-1:0] base,
  input  logic              big,
  input  logic [MEM_AW-1:0] insp_addr,
  input  logic              insp_we,
  input  logic [7:0]        insp_wdata,
  output logic [7:0]        insp_rdata,
  output logic              busy,
  output logic              erase_we
);

  localparam int DEPTH     = 1 << MEM_AW;
  localparam int CW        = $clog2(ERASE_CYCLES + 1);
  localparam int SMALL_LEN = 1 << BLK_AW;

  logic [7:0]        mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic [MEM_AW-1:0] base_q;
  logic              big_q;
  logic [CW-1:0]     blk_len;
  logic [MEM_AW-1:0] ers_addr;
  logic              host_we;

  assign blk_len  = big_q ? CW'(2 * SMALL_LEN) : CW'(SMALL_LEN);
  assign erase_we = busy && (cnt < blk_len);
  assign ers_addr = base_q + MEM_AW'(cnt);
  assign host_we  = insp_we && !busy;

  always_ff @(posedge clk) begin
    if (erase_we)     mem[ers_addr]  <= 8'hFF;
    else if (host_we) mem[insp_addr] <= insp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      base_q <= '0;
      big_q  <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      base_q <= base;
      big_q  <= big;
    end else if (busy) begin
      cnt <= cnt + CW'(1);
      if (cnt == CW'(ERASE_CYCLES - 1)) busy <= 1'b0;
    end
  end

  assign insp_rdata = mem[insp_addr];

endmodule

// File: rtl/spi_erase_resp.sv
module spi_erase_resp
  import spi_erase_pkg::*;
#(
  parameter int MEM_AW       = 10,
  parameter int BLK_AW       = 6,
  parameter int ERASE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso_d,
  output logic              miso_oe,
  input  logic              prot_en,
  input  logic [MEM_AW-1:0] prot_lo,
  input  logic [MEM_AW-1:0] prot_hi,
  input  logic [MEM_AW-1:0] insp_addr,
  input  logic              insp_we,
  input  logic [7:0]        insp_wdata,
  output logic [7:0]        insp_rdata
);

  localparam int CNT_W = 6;

  logic              frame_active, frame_end;
  logic [CNT_W-1:0]  bit_cnt;
  logic [7:0]        opcode;
  logic [MEM_AW-1:0] addr_lo;
  logic [7:0]        stat;
  logic              wel, busy, erase_start, erase_big, prot_hit, erase_we;
  logic [MEM_AW-1:0] erase_base;

  assign stat = stat_byte(busy, wel);

  spi_erase_link #(.CNT_W(CNT_W), .LOC_W(MEM_AW)) u_link (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .stat_in(stat), .frame_active(frame_active), .frame_end(frame_end),
    .bit_cnt(bit_cnt), .opcode(opcode), .addr_lo(addr_lo),
    .miso_d(miso_d), .miso_oe(miso_oe)
  );

  spi_erase_cmd #(.MEM_AW(MEM_AW), .BLK_AW(BLK_AW), .CNT_W(CNT_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .bit_cnt(bit_cnt),
    .opcode(opcode), .addr_lo(addr_lo), .busy(busy), .prot_en(prot_en),
    .prot_lo(prot_lo), .prot_hi(prot_hi), .wel(wel), .erase_start(erase_start),
    .erase_base(erase_base), .erase_big(erase_big), .prot_hit(prot_hit)
  );

  spi_erase_engine #(.MEM_AW(MEM_AW), .BLK_AW(BLK_AW), .ERASE_CYCLES(ERASE_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(erase_start), .base(erase_base), .big(erase_big),
    .insp_addr(insp_addr), .insp_we(insp_we), .insp_wdata(insp_wdata),
    .insp_rdata(insp_rdata), .busy(busy), .erase_we(erase_we)
  );

endmodule

// File: rtl/spi_erase_resp_chk.sv
module spi_erase_resp_chk #(
  parameter int ERASE_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic erase_start,
  input logic busy,
  input logic wel,
  input logic prot_hit,
  input logic erase_we,
  input logic miso_oe,
  input logic frame_active
);

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= busy ? run_len + 32'd1 : 32'd0;
  end

  assert_start_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(wel));

  assert_start_clears_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !wel);

  assert_no_protected_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !$past(prot_hit));

  assert_no_start_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !busy);

  assert_fill_inside_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |-> busy);

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 32'(ERASE_CYCLES)));

  assert_oe_inside_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> frame_active);

endmodule

bind spi_erase_resp spi_erase_resp_chk #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .erase_start(erase_start), .busy(busy), .wel(wel),
  .prot_hit(prot_hit), .erase_we(erase_we), .miso_oe(miso_oe), .frame_active(frame_active)
);

// File: tb/spi_erase_resp_tb.sv
module spi_erase_resp_tb_top;

  localparam int MEM_AW = 9;
  localparam int BLK_AW = 6;
  localparam int EC     = 500;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int HP     = 6;
  localparam int NV     = 9;

  // {mode3, wren, opcode[7:0], addr[23:0], prot_en, prot_lo[8:0], prot_hi[8:0]}
  localparam logic [52:0] VECS [NV] = '{
    {1'b0, 1'b1, 8'h52, 24'h000045, 1'b0, 9'h000, 9'h000},
    {1'b1, 1'b1, 8'hD8, 24'h0001F3, 1'b0, 9'h000, 9'h000},
    {1'b0, 1'b0, 8'h52, 24'h000080, 1'b0, 9'h000, 9'h000},
    {1'b0, 1'b1, 8'h52, 24'h0000C0, 1'b1, 9'h0E0, 9'h0E0},
    {1'b0, 1'b1, 8'h52, 24'h0000C0, 1'b1, 9'h100, 9'h1FF},
    {1'b1, 1'b1, 8'hD8, 24'hABC17F, 1'b1, 9'h180, 9'h1FF},
    {1'b0, 1'b1, 8'hD8, 24'h000000, 1'b1, 9'h07F, 9'h0FF},
    {1'b1, 1'b1, 8'h20, 24'h000040, 1'b0, 9'h000, 9'h000},
    {1'b0, 1'b1, 8'hD8, 24'hFFFE10, 1'b1, 9'h080, 9'h1FF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso_d, miso_oe;
  logic prot_en = 1'b0;
  logic [MEM_AW-1:0] prot_lo = '0, prot_hi = '0, insp_addr = '0;
  logic insp_we = 1'b0;
  logic [7:0] insp_wdata = '0, insp_rdata;

  logic [7:0] model [DEPTH];
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  spi_erase_resp #(.MEM_AW(MEM_AW), .BLK_AW(BLK_AW), .ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso_d(miso_d), .miso_oe(miso_oe), .prot_en(prot_en), .prot_lo(prot_lo),
    .prot_hi(prot_hi), .insp_addr(insp_addr), .insp_we(insp_we),
    .insp_wdata(insp_wdata), .insp_rdata(insp_rdata)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic spi_frame(input bit m3, input logic [63:0] bits, input int n,
                           output logic [7:0] rx, output logic oe_seen);
    logic [63:0] cap = '0;
    oe_seen = 1'b0;
    sck = m3;
    wait_clk(HP);
    cs_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < n; i++) begin
      sck  = 1'b0;
      mosi = bits[n-1-i];
      wait_clk(HP);
      cap = {cap[62:0], miso_d};
      if (i == n - 1) oe_seen = miso_oe;
      sck = 1'b1;
      wait_clk(HP);
    end
    if (!m3) begin
      sck = 1'b0;
      wait_clk(HP);
    end
    cs_n = 1'b1;
    wait_clk(2 * HP);
    rx = cap[7:0];
  endtask

  task automatic send(input bit m3, input logic [63:0] bits, input int n);
    logic [7:0] r;
    logic o;
    spi_frame(m3, bits, n, r, o);
  endtask

  task automatic read_stat(input bit m3, output logic [7:0] s, output logic oe);
    spi_frame(m3, {48'd0, 8'h05, 8'h00}, 16, s, oe);
  endtask

  task automatic host_write(input int a, input logic [7:0] d);
    insp_addr  = MEM_AW'(a);
    insp_wdata = d;
    insp_we    = 1'b1;
    wait_clk(1);
    insp_we    = 1'b0;
  endtask

  task automatic preload(input int seed);
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = {1'b0, 7'(a) ^ 7'(seed)};
      host_write(a, model[a]);
    end
  endtask

  task automatic compare_mem(input string req);
    int bad_a = -1;
    logic [7:0] got = '0;
    for (int a = 0; a < DEPTH; a++) begin
      insp_addr = MEM_AW'(a);
      #1;
      if (insp_rdata !== model[a] && bad_a < 0) begin
        bad_a = a;
        got   = insp_rdata;
      end
      wait_clk(1);
    end
    n_chk++;
    if (bad_a >= 0) begin
      n_bad++;
      $display("FAIL %s: byte %0d actual 0x%0h expected 0x%0h", req, bad_a, got, model[bad_a]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] st;
    logic oe;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // reset state
    chk("R9 reset oe", {31'd0, miso_oe}, 32'd0);
    read_stat(1'b0, st, oe);
    chk("R9 status after reset", {24'd0, st}, 32'h00);
    chk("R9 oe in data phase", {31'd0, oe}, 32'd1);
    chk("R9 oe after frame", {31'd0, miso_oe}, 32'd0);

    // write-enable of wrong length is ignored
    send(1'b0, {48'd0, 8'h06, 8'h00}, 16);
    read_stat(1'b0, st, oe);
    chk("R4 long wren ignored", {24'd0, st}, 32'h00);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [52:0] e = VECS[v];
      bit m3 = e[52], wr = e[51], pen = e[18];
      logic [7:0] op = e[50:43];
      logic [23:0] ad = e[42:19];
      int plo = int'(e[17:9]), phi = int'(e[8:0]);
      int len = (op == 8'hD8) ? 128 : (op == 8'h52) ? 64 : 0;
      int base = 0;
      bit hit = 0, go;
      string tag;
      if (len != 0) begin
        base = (int'(ad) % DEPTH) / len * len;
        hit  = pen && (base <= phi) && (plo <= base + len - 1);
      end
      go  = wr && (len != 0) && !hit;
      tag = !wr ? "R4 no wren" : hit ? "R3 protected" :
            (ad > 24'h1FF) ? "R2 high bits" : "R1 erase";
      preload(v * 13 + 1);
      prot_en = pen;
      prot_lo = MEM_AW'(plo);
      prot_hi = MEM_AW'(phi);
      if (wr) send(m3, {56'd0, 8'h06}, 8);
      send(m3, {32'd0, op, ad}, 32);
      wait_clk(EC + 20);
      if (go) for (int a = base; a < base + len; a++) model[a] = 8'hFF;
      compare_mem(tag);
      read_stat(m3, st, oe);
      chk("R7 latch after frame", {24'd0, st}, (wr && len == 0) ? 32'h02 : 32'h00);
    end
    prot_en = 1'b0;

    // write-enable in mode 3
    send(1'b1, {56'd0, 8'h06}, 8);
    read_stat(1'b1, st, oe);
    chk("R4 wren mode3", {24'd0, st}, 32'h02);

    // wrong-length erase frames
    preload(77);
    send(1'b0, {40'd0, 8'h52, 16'h0000}, 24);
    read_stat(1'b0, st, oe);
    chk("R5 short frame keeps latch", {24'd0, st}, 32'h02);
    send(1'b0, {24'd0, 8'h52, 24'h000000, 8'h00}, 40);
    wait_clk(EC + 20);
    compare_mem("R5 short and long frames");
    read_stat(1'b0, st, oe);
    chk("R5 long frame keeps latch", {24'd0, st}, 32'h02);

    // busy window behaviour
    send(1'b0, {32'd0, 8'h52, 24'h000000}, 32);
    read_stat(1'b0, st, oe);
    chk("R6 busy during erase", {24'd0, st}, 32'h01);
    host_write(300, 8'h11);
    send(1'b0, {56'd0, 8'h06}, 8);
    wait_clk(EC + 20);
    read_stat(1'b0, st, oe);
    chk("R8 wren ignored while busy", {24'd0, st}, 32'h00);
    for (int a = 0; a < 64; a++) model[a] = 8'hFF;
    compare_mem("R10 write ignored while busy");

    // inspection port when idle
    host_write(5, 8'h3C);
    insp_addr = MEM_AW'(5);
    #1;
    chk("R10 inspection write", {24'd0, insp_rdata}, 32'h3C);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule